// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a NOR-style flash controller. It watches bus write cycles, follows the multi-cycle unlock handshakes that guard destructive operations, and turns each completed sequence into a single-cycle request. The requests cover program, sector erase, block erase, chip erase, erase suspend and erase resume. The memory array and the erase engine that act on these requests lie outside the block. The same decoder also keeps the current read personality of the array port: normal array data, identification, query or security-ID space.

Write cycles arrive on a valid/ready channel. `wr_ready` is held high, so the decoder never applies back-pressure. A beat is consumed in every clock cycle where `wr_valid` is high, and the upstream side may issue beats back to back. The erase engine feeds back two plain status levels, `busy` and `suspended`. A write-protect level, `wp_n`, gates chip erase. Every request pulse is registered and appears in the clock cycle after the write beat that completes its sequence. On a launch, the target address and data from that same beat are held on `tgt_addr` and `tgt_data` until the next launch.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the decoder returns to idle, drives all request pulses low, sets `rd_mode` to 0 (array read) and clears `tgt_addr` and `tgt_data`. `wr_ready` is always 1.
- R2: Only `wr_addr[10:0]` and `wr_data[7:0]` take part in command matching. The unlock prefix is data AAh at address 555h followed by data 55h at address 2AAh. When a beat does not fit the sequence in progress and `busy` is low, the decoder returns to idle and sets `rd_mode` to 0, with no request.
- R3: The prefix, then A0h at 555h, then any fourth beat gives a `req_program` pulse. `tgt_addr` and `tgt_data` then show the full address and data of that fourth beat.
- R4: The prefix, then 80h at 555h, AAh at 555h and 55h at 2AAh, then a sixth beat of 50h gives `req_sector_erase`. A sixth beat of 30h instead gives `req_block_erase`. In both cases the sixth beat's address and data are captured.
- R5: A sixth beat of 10h at 555h gives `req_chip_erase` when `wp_n` is 1. When `wp_n` is 0 the request is dropped: no pulse, the decoder returns to idle, and `rd_mode` is unchanged.
- R6: The prefix plus 90h, 98h or 88h at 555h sets `rd_mode` to 1 (identification), 2 (query) or 3 (security-ID). A lone 98h at address 055h from idle also sets `rd_mode` to 2.
- R7: F0h sets `rd_mode` to 0. It may be sent as a lone beat at any address from idle, or as the prefix plus F0h at 555h.
- R8: B0h at any address gives `req_suspend` only when `busy` is 1, `suspended` is 0, and the last erase-class launch made while not suspended was a sector or block erase.
- R9: 30h at any address, sent from idle, gives `req_resume` when `suspended` is 1 and `busy` is 0.
- R10: While `busy` is 1, every beat other than an honoured suspend is ignored: no pulse, no change to `rd_mode` or the sequence position.
- R11: At most one request pulse is high in any cycle. Each pulse lasts exactly one cycle, and only in the cycle after an accepted write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Beat accepted (always 1) |
| wr_addr | input | ADDR_W (21) | Write address |
| wr_data | input | DATA_W (16) | Write data |
| busy | input | 1 | Internal program/erase in progress |
| suspended | input | 1 | An erase is held in suspend |
| wp_n | input | 1 | Write protect, low blocks chip erase |
| req_program | output | 1 | Program request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_block_erase | output | 1 | Block erase request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query, 3 security-ID |
| tgt_addr | output | ADDR_W (21) | Address captured at launch |
| tgt_data | output | DATA_W (16) | Data captured at launch |

## Verification
Two functions can collide in one cycle: the engine can finish an operation, with `busy` falling, in the same cycle that a write beat lands. That beat is then either a candidate suspend or a beat to be ignored, or it is a fresh command or an abort. The bench provokes this by changing `busy` and `suspended` at random just before each beat, including the beat that follows a launch. A bench model then uses the levels sampled in that exact cycle to decide between a pulse, a silent drop and an abort to array mode. Directed cases pin down the same boundary: suspend honoured after an erase but refused after a program, resume refused while busy, and chip erase with write protect asserted.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMP_AW = 11;
  localparam int CMP_DW = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM, S_ERS1, S_ERS2, S_ERS3
  } seq_t;

  typedef enum logic [1:0] {
    M_ARRAY = 2'd0, M_IDENT = 2'd1, M_QUERY = 2'd2, M_SECID = 2'd3
  } rmode_t;

  typedef enum logic [3:0] {
    C_NONE, C_AA, C_55, C_A0, C_80, C_50, C_30, C_10,
    C_B0, C_90, C_98, C_88, C_F0
  } code_t;

  typedef struct packed {
    logic k555;
    logic k2aa;
    logic k055;
  } amatch_t;

  typedef struct packed {
    logic pgm;
    logic sec;
    logic blk;
    logic chip;
    logic sus;
    logic res;
  } req_t;
endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
(
  input  logic [CMP_AW-1:0] addr_lo,
  input  logic [CMP_DW-1:0] data_lo,
  output amatch_t           am,
  output code_t             code
);
  localparam int NKEY = 3;
  localparam logic [CMP_AW-1:0] KEYS [NKEY] = '{11'h555, 11'h2AA, 11'h055};

  logic [NKEY-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NKEY; gi++) begin : g_key
      assign hit[gi] = (addr_lo == KEYS[gi]);
    end
  endgenerate

  assign am.k555 = hit[0];
  assign am.k2aa = hit[1];
  assign am.k055 = hit[2];

  always_comb begin
    case (data_lo)
      8'hAA:   code = C_AA;
      8'h55:   code = C_55;
      8'hA0:   code = C_A0;
      8'h80:   code = C_80;
      8'h50:   code = C_50;
      8'h30:   code = C_30;
      8'h10:   code = C_10;
      8'hB0:   code = C_B0;
      8'h90:   code = C_90;
      8'h98:   code = C_98;
      8'h88:   code = C_88;
      8'hF0:   code = C_F0;
      default: code = C_NONE;
    endcase
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_valid,
  input  amatch_t am,
  input  code_t   code,
  input  logic    busy,
  input  logic    suspended,
  input  logic    wp_n,
  output req_t    req,
  output rmode_t  mode,
  output logic    capture
);
  seq_t   st, nxt_st;
  rmode_t nxt_mode;
  req_t   nreq;
  logic   ers_q, nxt_ers;
  logic   abort;

  always_comb begin
    nxt_st   = st;
    nxt_mode = mode;
    nreq     = '0;
    nxt_ers  = ers_q;
    capture  = 1'b0;
    abort    = 1'b0;
    if (wr_valid) begin
      if (busy) begin
        if (code == C_B0 && !suspended && ers_q) nreq.sus = 1'b1;
      end else begin
        nxt_st = S_IDLE;
        unique case (st)
          S_IDLE: begin
            if (code == C_AA && am.k555)      nxt_st   = S_UNL1;
            else if (code == C_F0)            nxt_mode = M_ARRAY;
            else if (code == C_98 && am.k055) nxt_mode = M_QUERY;
            else if (code == C_30 && suspended) nreq.res = 1'b1;
            else                              abort    = 1'b1;
          end
          S_UNL1: begin
            if (code == C_55 && am.k2aa) nxt_st = S_UNL2;
            else                         abort  = 1'b1;
          end
          S_UNL2: begin
            if (!am.k555) abort = 1'b1;
            else begin
              case (code)
                C_A0:    nxt_st   = S_PGM;
                C_80:    nxt_st   = S_ERS1;
                C_90:    nxt_mode = M_IDENT;
                C_98:    nxt_mode = M_QUERY;
                C_88:    nxt_mode = M_SECID;
                C_F0:    nxt_mode = M_ARRAY;
                default: abort    = 1'b1;
              endcase
            end
          end
          S_PGM: begin
            nreq.pgm = 1'b1;
            capture  = 1'b1;
            if (!suspended) nxt_ers = 1'b0;
          end
          S_ERS1: begin
            if (code == C_AA && am.k555) nxt_st = S_ERS2;
            else                         abort  = 1'b1;
          end
          S_ERS2: begin
            if (code == C_55 && am.k2aa) nxt_st = S_ERS3;
            else                         abort  = 1'b1;
          end
          S_ERS3: begin
            if (code == C_50) begin
              nreq.sec = 1'b1; capture = 1'b1; nxt_ers = 1'b1;
            end else if (code == C_30) begin
              nreq.blk = 1'b1; capture = 1'b1; nxt_ers = 1'b1;
            end else if (code == C_10 && am.k555) begin
              if (wp_n) begin
                nreq.chip = 1'b1; capture = 1'b1;
                if (!suspended) nxt_ers = 1'b0;
              end
            end else abort = 1'b1;
          end
          default: abort = 1'b1;
        endcase
        if (abort) nxt_mode = M_ARRAY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      mode  <= M_ARRAY;
      req   <= '0;
      ers_q <= 1'b0;
    end else begin
      st    <= nxt_st;
      mode  <= nxt_mode;
      req   <= nreq;
      ers_q <= nxt_ers;
    end
  end

  // R11: never two requests together
  a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));
  // R11: a pulse always follows an accepted beat
  a_r11_req_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $past(wr_valid));
  // R5: chip erase only with write protect released
  a_r5_wp_blocks_chip: assert property (@(posedge clk) disable iff (!rst_n)
    req.chip |-> $past(wp_n));
  // R10: launches and resume never while busy
  a_r10_busy_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (req.pgm || req.sec || req.blk || req.chip || req.res) |-> !$past(busy));
  // R8: suspend only while an unsuspended operation runs
  a_r8_suspend_gate: assert property (@(posedge clk) disable iff (!rst_n)
    req.sus |-> ($past(busy) && !$past(suspended)));
  // R9: resume only from suspend
  a_r9_resume_gate: assert property (@(posedge clk) disable iff (!rst_n)
    req.res |-> $past(suspended));
  // R10: read mode holds without a beat or while busy
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid || busy) |=> $stable(mode));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              suspended,
  input  logic              wp_n,
  output logic              req_program,
  output logic              req_sector_erase,
  output logic              req_block_erase,
  output logic              req_chip_erase,
  output logic              req_suspend,
  output logic              req_resume,
  output logic [1:0]        rd_mode,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);
  localparam bit WIDTHS_OK = (ADDR_W >= CMP_AW) && (DATA_W >= CMP_DW);

  amatch_t am;
  code_t   code;
  req_t    req;
  rmode_t  mode;
  logic    capture;

  initial if (!WIDTHS_OK) $error("address or data narrower than command fields");

  fcd_classify u_cls (
    .addr_lo (wr_addr[CMP_AW-1:0]),
    .data_lo (wr_data[CMP_DW-1:0]),
    .am      (am),
    .code    (code)
  );

  fcd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .am        (am),
    .code      (code),
    .busy      (busy),
    .suspended (suspended),
    .wp_n      (wp_n),
    .req       (req),
    .mode      (mode),
    .capture   (capture)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      tgt_data <= '0;
    end else if (capture) begin
      tgt_addr <= wr_addr;
      tgt_data <= wr_data;
    end
  end

  assign wr_ready         = 1'b1;
  assign req_program      = req.pgm;
  assign req_sector_erase = req.sec;
  assign req_block_erase  = req.blk;
  assign req_chip_erase   = req.chip;
  assign req_suspend      = req.sus;
  assign req_resume       = req.res;
  assign rd_mode          = mode;

  // R3: program target holds the fourth beat's data
  a_r3_capture_data: assert property (@(posedge clk) disable iff (!rst_n)
    req_program |-> (tgt_data == $past(wr_data)));
  // R4: erase target holds the sixth beat's address
  a_r4_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sector_erase || req_block_erase) |-> (tgt_addr == $past(wr_addr)));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [20:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0, suspended = 1'b0, wp_n = 1'b1;
  logic        req_program, req_sector_erase, req_block_erase;
  logic        req_chip_erase, req_suspend, req_resume;
  logic [1:0]  rd_mode;
  logic [20:0] tgt_addr;
  logic [15:0] tgt_data;

  int errs = 0, checks = 0;
  bit finished = 1'b0;

  // model state: 0 idle,1 unl1,2 unl2,3 pgm,4 ers1,5 ers2,6 ers3
  int          ms = 0;
  logic [1:0]  mm = 2'd0;
  bit          meq = 1'b0;
  logic [5:0]  xr = '0; // {pgm,sec,blk,chip,sus,res}
  logic [20:0] xa = '0;
  logic [15:0] xd = '0;

  always #2 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .suspended(suspended),
    .wp_n(wp_n), .req_program(req_program), .req_sector_erase(req_sector_erase),
    .req_block_erase(req_block_erase), .req_chip_erase(req_chip_erase),
    .req_suspend(req_suspend), .req_resume(req_resume), .rd_mode(rd_mode),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  task automatic check(input string tag);
    logic [5:0] got;
    got = {req_program, req_sector_erase, req_block_erase,
           req_chip_erase, req_suspend, req_resume};
    checks++;
    if (got !== xr || rd_mode !== mm || tgt_addr !== xa ||
        tgt_data !== xd || wr_ready !== 1'b1) begin
      errs++;
      $display("FAIL %s: req=%b exp=%b mode=%0d exp=%0d addr=%h exp=%h data=%h exp=%h rdy=%b",
               tag, got, xr, rd_mode, mm, tgt_addr, xa, tgt_data, xd, wr_ready);
    end
  endtask

  task automatic launch(input int bitpos, input logic [20:0] a, input logic [15:0] d);
    xr[bitpos] = 1'b1; xa = a; xd = d; ms = 0;
  endtask

  task automatic m_step(input logic [20:0] a, input logic [15:0] d);
    logic [10:0] al;
    logic [7:0]  dl;
    bit bad;
    al = a[10:0]; dl = d[7:0]; bad = 1'b0; xr = '0;
    if (busy) begin
      if (dl == 8'hB0 && !suspended && meq) xr[1] = 1'b1;
      return;
    end
    case (ms)
      0: begin
        ms = 0;
        if (dl == 8'hAA && al == 11'h555) ms = 1;
        else if (dl == 8'hF0) mm = 2'd0;
        else if (dl == 8'h98 && al == 11'h055) mm = 2'd2;
        else if (dl == 8'h30 && suspended) xr[0] = 1'b1;
        else bad = 1'b1;
      end
      1: begin ms = 0; if (dl == 8'h55 && al == 11'h2AA) ms = 2; else bad = 1'b1; end
      2: begin
        ms = 0;
        if (al != 11'h555) bad = 1'b1;
        else case (dl)
          8'hA0: ms = 3;
          8'h80: ms = 4;
          8'h90: mm = 2'd1;
          8'h98: mm = 2'd2;
          8'h88: mm = 2'd3;
          8'hF0: mm = 2'd0;
          default: bad = 1'b1;
        endcase
      end
      3: begin launch(5, a, d); if (!suspended) meq = 1'b0; end
      4: begin ms = 0; if (dl == 8'hAA && al == 11'h555) ms = 5; else bad = 1'b1; end
      5: begin ms = 0; if (dl == 8'h55 && al == 11'h2AA) ms = 6; else bad = 1'b1; end
      default: begin
        ms = 0;
        if (dl == 8'h50) begin launch(4, a, d); meq = 1'b1; end
        else if (dl == 8'h30) begin launch(3, a, d); meq = 1'b1; end
        else if (dl == 8'h10 && al == 11'h555) begin
          if (wp_n) begin launch(2, a, d); if (!suspended) meq = 1'b0; end
        end else bad = 1'b1;
      end
    endcase
    if (bad) mm = 2'd0;
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d, input string tag);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    m_step(a, d);
    @(negedge clk);
    wr_valid = 1'b0;
    check(tag);
  endtask

  task automatic idle(input string tag);
    xr = '0;
    @(negedge clk);
    check(tag);
  endtask

  task automatic prefix(input string tag);
    wr(21'h1FF555, 16'h12AA, tag);  // upper bits differ, low fields match
    wr(21'h0002AA, 16'h0055, tag);
  endtask

  task automatic erase6(input logic [20:0] a, input logic [15:0] d, input string tag);
    prefix(tag);
    wr(21'h000555, 16'h0080, tag);
    prefix(tag);
    wr(a, d, tag);
  endtask

  // random sequence: kind selects command, corrupt picks a beat to disturb
  task automatic rand_seq;
    logic [20:0] aa [6];
    logic [15:0] dd [6];
    int n, kind, cor;
    logic [10:0] hi;
    kind = $urandom_range(0, 11);
    cor  = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 5) : -1;
    aa[0] = 21'h555; dd[0] = 16'hAA; aa[1] = 21'h2AA; dd[1] = 16'h55;
    aa[2] = 21'h555; aa[3] = 21'h555; dd[3] = 16'hAA; aa[4] = 21'h2AA; dd[4] = 16'h55;
    aa[5] = 21'h555; dd[2] = 16'h80; dd[5] = 16'h10; n = 6;
    case (kind)
      0: begin dd[2] = 16'hA0; n = 4; aa[3] = 21'($urandom); dd[3] = 16'($urandom); end
      1: begin dd[5] = 16'h50; aa[5] = 21'($urandom); end
      2: begin dd[5] = 16'h30; aa[5] = 21'($urandom); end
      3: ;
      4: begin dd[2] = 16'h90; n = 3; end
      5: begin dd[2] = 16'h98; n = 3; end
      6: begin dd[2] = 16'h88; n = 3; end
      7: begin dd[2] = 16'hF0; n = 3; end
      8: begin aa[0] = 21'h055; dd[0] = 16'h98; n = 1; end
      9: begin aa[0] = 21'($urandom); dd[0] = 16'hF0; n = 1; end
      10: begin aa[0] = 21'($urandom); dd[0] = 16'hB0; n = 1; end
      default: begin aa[0] = 21'($urandom); dd[0] = 16'h30; n = 1; end
    endcase
    for (int i = 0; i < n; i++) begin
      hi = 11'($urandom);
      if ($urandom_range(0, 7) == 0) begin busy = $urandom_range(0, 1); suspended = $urandom_range(0, 1); end
      if ($urandom_range(0, 7) == 0) wp_n = $urandom_range(0, 1);
      if (i == cor) dd[i][0] = ~dd[i][0];
      wr({hi[9:0], aa[i][10:0]}, {hi[7:0], dd[i][7:0]}, "R11");
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: run did not complete, got=hang exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1");                 // reset state
    rst_n = 1'b1;
    idle("R1");

    // R6: mode entries
    prefix("R6"); wr(21'h000555, 16'h0090, "R6");
    prefix("R6"); wr(21'h000555, 16'h0088, "R6");
    wr(21'h100055, 16'hFF98, "R6");            // lone query entry
    // R7: exits
    wr(21'h0ABCDE, 16'h00F0, "R7");
    prefix("R7"); wr(21'h000555, 16'h0098, "R7");
    prefix("R7"); wr(21'h000555, 16'h00F0, "R7");
    // R2: corrupted second beat aborts to array mode
    prefix("R2"); wr(21'h000555, 16'h0090, "R2");
    wr(21'h000555, 16'h00AA, "R2"); wr(21'h0002AB, 16'h0055, "R2");
    wr(21'h000555, 16'h00A0, "R2");            // not a program: idle + abort
    idle("R2");
    // R3: program with upper bits in the prefix ignored
    prefix("R3"); wr(21'h000555, 16'h00A0, "R3"); wr(21'h012345, 16'hBEEF, "R3");
    idle("R11");                                // pulse has ended
    // R4: sector and block erase
    erase6(21'h00A800, 16'h0050, "R4");
    erase6(21'h1F8000, 16'h0030, "R4");
    // R5: chip erase with and without protection
    wp_n = 1'b0; erase6(21'h000555, 16'h0010, "R5"); idle("R5");
    wp_n = 1'b1; erase6(21'h000555, 16'h0010, "R5");
    // R8/R9: suspend after a block erase, then resume
    erase6(21'h040000, 16'h0030, "R8");
    busy = 1'b1; wr(21'h0FFFFF, 16'h00B0, "R8");
    busy = 1'b0; suspended = 1'b1; wr(21'h012345, 16'h0030, "R9");
    busy = 1'b1; wr(21'h012345, 16'h0030, "R9");  // refused while busy
    busy = 1'b0; suspended = 1'b0;
    // R10: after a program, suspend is refused and other beats ignored
    prefix("R10"); wr(21'h000555, 16'h0090, "R10");
    prefix("R10"); wr(21'h000555, 16'h00A0, "R10"); wr(21'h000100, 16'h1234, "R10");
    busy = 1'b1;
    wr(21'h000000, 16'h00B0, "R10");
    wr(21'h000000, 16'h00F0, "R10");
    prefix("R10"); wr(21'h000555, 16'h00A0, "R10"); wr(21'h000200, 16'h5678, "R10");
    busy = 1'b0; idle("R10");

    for (int k = 0; k < 2500; k++) rand_seq();
    busy = 1'b0; idle("R11");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule